// File: doc/BRIEF.md
# Host Bridge Configuration Space with Shadow Region Decoder

This block holds the configuration register space of a host bridge and decodes the shadow attributes of the upper BIOS region from it. Software reaches the registers through a small access port: a function number, an 8-bit register index, a write strobe with data, and a read strobe that returns data in the same cycle. Every write goes through a filter for its register. The filter can drop the write, force bits to fixed values, or store the byte as given.

The decoder watches a 20-bit physical address and a write flag. It reports whether the access belongs to one of the four 16 KB shadow segments in the 64 KB window at 0xE0000, and whether internal DRAM or the external bus serves it. One bit per segment enables that segment. A 2-bit global mode field sets the read target and the write target separately. The decode is combinational from the current register contents.

A two-state controller handles the soft reset. In `ST_IDLE` the port works normally. A `soft_rst` pulse takes it to `ST_SHADOW_OFF` (transition *soft-reset request*). It stays there for exactly one cycle. At the end of that cycle the segment enable bits are cleared and any configuration write in that cycle is dropped. It then returns to `ST_IDLE` (transition *shadow cleared*). A hardware reset (`rst_n` low) loads the full default image and enters `ST_IDLE`.

Top module: `hb_cfg_shadow`

## Requirements
- R1: After `rst_n` is released, reads return 0x39, 0x10, 0x06, 0x04 at 0x00–0x03, 0x07 at 0x04, 0x00 at 0x05, 0x80 at 0x06, 0x02 at 0x07, 0x00/0x00/0x06 at 0x09/0x0A/0x0B, 0xBC, 0xFB, 0xAD, 0xFE at 0x50–0x53, and 0x00 at every other index, including 0x54.
- R2: When `cfg_func` is nonzero, a read returns 0xFF and a write changes no register.
- R3: Writes are dropped at indices 0x00–0x03, 0x08–0x0C, 0x0E and 0x10–0x4E.
- R4: A write to 0x04 stores (data AND 0x42) OR 0x04. A write to 0x05 stores data AND 0x01.
- R5: A write to 0x06 stores 0x00. A write to 0x07 stores 0x02, whatever the data.
- R6: A write to any other index (for example 0x0D, 0x0F, 0x4F–0xFF) stores the whole byte. A function-0 read returns the stored byte in the cycle `cfg_rd` is high. With `cfg_rd` low, `cfg_rdata` is 0x00.
- R7: Segment d (0–3) covers 0xE0000 + d·0x4000 up to +0x3FFF. Bit 4+d of register 0x54 enables it. `mem_shadow_hit` is high only for an address in an enabled segment.
- R8: For an enabled segment, bits 6:5 of register 0x53 set the target (1 means internal on `mem_internal`). 00 gives read external and write internal. 01 gives both external. 10 gives both internal. 11 gives read internal and write external.
- R9: An address in a disabled segment, or outside 0xE0000–0xEFFFF, gives `mem_internal` = 0 and `mem_shadow_hit` = 0.
- R10: When `soft_rst` is high in `ST_IDLE`, the next cycle is `ST_SHADOW_OFF`. At the end of that cycle register 0x54 keeps only its low 4 bits, a configuration write in that cycle is dropped, and the controller returns to `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Soft reset request, one-cycle pulse |
| cfg_func | input | 3 | Function number of the configuration access |
| cfg_addr | input | 8 | Register index |
| cfg_wr | input | 1 | Write strobe |
| cfg_wdata | input | 8 | Write data |
| cfg_rd | input | 1 | Read strobe |
| cfg_rdata | output | 8 | Read data, valid in the strobe cycle |
| mem_addr | input | 20 | Physical address to decode |
| mem_we | input | 1 | 1 for a write access, 0 for a read |
| mem_shadow_hit | output | 1 | Address falls in an enabled shadow segment |
| mem_internal | output | 1 | Access is served by internal DRAM |

## Verification
Register state can only be seen through the port one cycle after the write that set it, either by reading the index back or through the decoder outputs. A wrong mask or a dropped write therefore shows up on the first read after the write. A wrong enable bit or mode bit changes `mem_internal` or `mem_shadow_hit` as soon as an address in the affected segment is presented. A controller that stays in `ST_SHADOW_OFF` or never enters it is visible two cycles after the `soft_rst` pulse: either register 0x54 keeps its high nibble, or a write issued after the clear is lost.

// File: rtl/hb_cfg_pkg.sv
package hb_cfg_pkg;

    localparam int REG_AW = 8;
    localparam int REG_DW = 8;

    typedef enum logic [0:0] {
        ST_IDLE       = 1'b0,
        ST_SHADOW_OFF = 1'b1
    } hb_state_e;

    // Default image loaded by hardware reset
    function automatic logic [REG_DW-1:0] reset_value(input logic [REG_AW-1:0] idx);
        logic [REG_DW-1:0] v;
        unique case (idx)
            8'h00:   v = 8'h39;
            8'h01:   v = 8'h10;
            8'h02:   v = 8'h06;
            8'h03:   v = 8'h04;
            8'h04:   v = 8'h07;
            8'h06:   v = 8'h80;
            8'h07:   v = 8'h02;
            8'h0B:   v = 8'h06;
            8'h50:   v = 8'hBC;
            8'h51:   v = 8'hFB;
            8'h52:   v = 8'hAD;
            8'h53:   v = 8'hFE;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/hb_wmask.sv
module hb_wmask
    import hb_cfg_pkg::*;
(
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_DW-1:0] wdata,
    output logic              keep,
    output logic [REG_DW-1:0] value
);
    logic read_only;

    always_comb begin
        read_only = (addr <= 8'h03) ||
                    ((addr >= 8'h08) && (addr <= 8'h0C)) ||
                    (addr == 8'h0E) ||
                    ((addr >= 8'h10) && (addr <= 8'h4E));
        keep  = !read_only;
        value = wdata;
        unique case (addr)
            8'h04:   value = (wdata & 8'h42) | 8'h04;
            8'h05:   value = wdata & 8'h01;
            8'h06:   value = 8'h00;
            8'h07:   value = 8'h02;
            default: value = wdata;
        endcase
    end
endmodule

// File: rtl/hb_regfile.sv
module hb_regfile
    import hb_cfg_pkg::*;
#(
    parameter int MODE_IDX = 8'h53,
    parameter int ENA_IDX  = 8'h54,
    parameter int CMD_IDX  = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  logic [REG_DW-1:0] wdata,
    input  logic              shadow_clr,
    input  logic [REG_AW-1:0] raddr,
    output logic [REG_DW-1:0] rdata,
    output logic [REG_DW-1:0] mode_q,
    output logic [REG_DW-1:0] ena_q,
    output logic [REG_DW-1:0] cmd_q
);
    localparam int DEPTH = 1 << REG_AW;

    logic [REG_DW-1:0] regs [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                regs[i] <= reset_value(REG_AW'(i));
            end
        end else if (shadow_clr) begin
            regs[ENA_IDX] <= regs[ENA_IDX] & 8'h0F;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata  = regs[raddr];
    assign mode_q = regs[MODE_IDX];
    assign ena_q  = regs[ENA_IDX];
    assign cmd_q  = regs[CMD_IDX];
endmodule

// File: rtl/hb_shadow_dec.sv
module hb_shadow_dec #(
    parameter int          ADDR_W   = 20,
    parameter int          SEG_BITS = 2,
    parameter int          SEG_SHIFT = 14,
    parameter logic [19:0] WIN_BASE = 20'hE0000,
    parameter int          ENA_LSB  = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [7:0]        ena_reg,
    input  logic [1:0]        mode,
    output logic              hit,
    output logic              internal
);
    localparam int SEG_COUNT = 1 << SEG_BITS;
    localparam int TAG_LSB   = SEG_SHIFT + SEG_BITS;
    localparam int TAG_W     = ADDR_W - TAG_LSB;
    localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:TAG_LSB];

    logic                in_win;
    logic [SEG_BITS-1:0] seg_idx;
    logic [SEG_COUNT-1:0] seg_hit;

    assign in_win  = (addr[ADDR_W-1:TAG_LSB] == WIN_TAG);
    assign seg_idx = addr[TAG_LSB-1:SEG_SHIFT];

    for (genvar d = 0; d < SEG_COUNT; d++) begin : g_seg
        assign seg_hit[d] = in_win && (seg_idx == SEG_BITS'(d)) && ena_reg[ENA_LSB+d];
    end

    // mode[1]: reads internal, mode[0] low: writes internal
    assign hit      = |seg_hit;
    assign internal = hit && (we ? !mode[0] : mode[1]);
endmodule

// File: rtl/hb_cfg_shadow.sv
module hb_cfg_shadow
    import hb_cfg_pkg::*;
#(
    parameter int FUNC_W = 3,
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [FUNC_W-1:0] cfg_func,
    input  logic [7:0]        cfg_addr,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_wdata,
    input  logic              cfg_rd,
    output logic [7:0]        cfg_rdata,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_we,
    output logic              mem_shadow_hit,
    output logic              mem_internal
);
    hb_state_e   state_q, state_d;
    logic        shadow_clr, wr_allow;
    logic        mask_keep;
    logic [7:0]  mask_val;
    logic [7:0]  store_rdata, shadow_mode_q, shadow_ena_q, cmd_q;
    logic        func_ok;

    assign func_ok = (cfg_func == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        shadow_clr = 1'b0;
        wr_allow   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                wr_allow = 1'b1;
                if (soft_rst) state_d = ST_SHADOW_OFF;
            end
            ST_SHADOW_OFF: begin
                shadow_clr = 1'b1;
                state_d    = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    hb_wmask u_mask (
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .keep  (mask_keep),
        .value (mask_val)
    );

    hb_regfile u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_wr && func_ok && mask_keep && wr_allow),
        .waddr      (cfg_addr),
        .wdata      (mask_val),
        .shadow_clr (shadow_clr),
        .raddr      (cfg_addr),
        .rdata      (store_rdata),
        .mode_q     (shadow_mode_q),
        .ena_q      (shadow_ena_q),
        .cmd_q      (cmd_q)
    );

    always_comb begin
        if (!cfg_rd)       cfg_rdata = 8'h00;
        else if (!func_ok) cfg_rdata = 8'hFF;
        else               cfg_rdata = store_rdata;
    end

    hb_shadow_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr     (mem_addr),
        .we       (mem_we),
        .ena_reg  (shadow_ena_q),
        .mode     (shadow_mode_q[6:5]),
        .hit      (mem_shadow_hit),
        .internal (mem_internal)
    );
endmodule

// File: rtl/hb_cfg_shadow_chk.sv
module hb_cfg_shadow_chk #(
    parameter int FUNC_W = 3,
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [FUNC_W-1:0] cfg_func,
    input logic [7:0]        cfg_addr,
    input logic              cfg_wr,
    input logic              cfg_rd,
    input logic [7:0]        cfg_rdata,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_shadow_hit,
    input logic              mem_internal,
    input logic              state_q,
    input logic [7:0]        shadow_ena_q,
    input logic [7:0]        cmd_q
);
    assert_foreign_func_ff_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && cfg_func != '0) |-> cfg_rdata == 8'hFF);

    assert_cmd_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_func == '0 && cfg_addr == 8'h04 && !state_q)
        |=> (cmd_q[2] && ((cmd_q & 8'hB9) == 8'h00)));

    assert_idle_rdata_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd |-> cfg_rdata == 8'h00);

    assert_outside_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr[ADDR_W-1:ADDR_W-4] != 4'hE) |-> (!mem_internal && !mem_shadow_hit));

    assert_no_hit_external_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_shadow_hit |-> !mem_internal);

    assert_shadow_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
        state_q |=> (shadow_ena_q[7:4] == 4'h0 && !state_q));
endmodule

bind hb_cfg_shadow hb_cfg_shadow_chk #(.FUNC_W(FUNC_W), .ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_func       (cfg_func),
    .cfg_addr       (cfg_addr),
    .cfg_wr         (cfg_wr),
    .cfg_rd         (cfg_rd),
    .cfg_rdata      (cfg_rdata),
    .mem_addr       (mem_addr),
    .mem_shadow_hit (mem_shadow_hit),
    .mem_internal   (mem_internal),
    .state_q        (state_q),
    .shadow_ena_q   (shadow_ena_q),
    .cmd_q          (cmd_q)
);

// File: tb/hb_cfg_shadow_test.sv
`timescale 1ns/1ps
module hb_cfg_shadow_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [2:0]  cfg_func = '0;
    logic [7:0]  cfg_addr = '0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        cfg_rd = 1'b0;
    logic [7:0]  cfg_rdata;
    logic [19:0] mem_addr = '0;
    logic        mem_we = 1'b0;
    logic        mem_shadow_hit, mem_internal;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    hb_cfg_shadow uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .cfg_func(cfg_func), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata),
        .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_shadow_hit(mem_shadow_hit), .mem_internal(mem_internal)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] f, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_func = f; cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read_chk(input string req, input logic [2:0] f,
                                input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        cfg_func = f; cfg_addr = a; cfg_rd = 1'b1;
        #1;
        check(req, cfg_rdata, exp);
        cfg_rd = 1'b0;
    endtask

    task automatic dec_chk(input string req, input logic [19:0] a, input logic w,
                           input logic exp_hit, input logic exp_int);
        @(negedge clk);
        mem_addr = a; mem_we = w;
        #1;
        check({req, " hit"}, mem_shadow_hit, exp_hit);
        check({req, " internal"}, mem_internal, exp_int);
    endtask

    task automatic t_reset_image;
        cfg_read_chk("R1 id0", 0, 8'h00, 8'h39);
        cfg_read_chk("R1 id1", 0, 8'h01, 8'h10);
        cfg_read_chk("R1 id2", 0, 8'h02, 8'h06);
        cfg_read_chk("R1 id3", 0, 8'h03, 8'h04);
        cfg_read_chk("R1 cmd", 0, 8'h04, 8'h07);
        cfg_read_chk("R1 st0", 0, 8'h06, 8'h80);
        cfg_read_chk("R1 st1", 0, 8'h07, 8'h02);
        cfg_read_chk("R1 cls", 0, 8'h0B, 8'h06);
        cfg_read_chk("R1 r50", 0, 8'h50, 8'hBC);
        cfg_read_chk("R1 r53", 0, 8'h53, 8'hFE);
        cfg_read_chk("R1 r54", 0, 8'h54, 8'h00);
        @(negedge clk); cfg_addr = 8'h00; #1;
        check("R6 no strobe", cfg_rdata, 8'h00);
    endtask

    task automatic t_foreign_func;
        cfg_write(3'd1, 8'h60, 8'h5A);
        cfg_read_chk("R2 write ignored", 0, 8'h60, 8'h00);
        cfg_read_chk("R2 read ff", 3'd5, 8'h00, 8'hFF);
    endtask

    task automatic t_read_only;
        cfg_write(0, 8'h00, 8'hAA);
        cfg_read_chk("R3 idx00", 0, 8'h00, 8'h39);
        cfg_write(0, 8'h0C, 8'hAA);
        cfg_read_chk("R3 idx0c", 0, 8'h0C, 8'h00);
        cfg_write(0, 8'h20, 8'hAA);
        cfg_read_chk("R3 idx20", 0, 8'h20, 8'h00);
        cfg_write(0, 8'h4E, 8'hAA);
        cfg_read_chk("R3 idx4e", 0, 8'h4E, 8'h00);
    endtask

    task automatic t_masks;
        cfg_write(0, 8'h04, 8'hFF);
        cfg_read_chk("R4 cmd ff", 0, 8'h04, 8'h46);
        cfg_write(0, 8'h04, 8'h00);
        cfg_read_chk("R4 cmd 00", 0, 8'h04, 8'h04);
        cfg_write(0, 8'h05, 8'hFF);
        cfg_read_chk("R4 cmd hi", 0, 8'h05, 8'h01);
        cfg_write(0, 8'h06, 8'hFF);
        cfg_read_chk("R5 st0", 0, 8'h06, 8'h00);
        cfg_write(0, 8'h07, 8'h00);
        cfg_read_chk("R5 st1", 0, 8'h07, 8'h02);
        cfg_write(0, 8'h0D, 8'hC3);
        cfg_read_chk("R6 idx0d", 0, 8'h0D, 8'hC3);
        cfg_write(0, 8'h4F, 8'h3C);
        cfg_read_chk("R6 idx4f", 0, 8'h4F, 8'h3C);
    endtask

    task automatic t_shadow;
        dec_chk("R9 all disabled", 20'hE0000, 0, 0, 0);
        cfg_write(0, 8'h54, 8'hF5);
        dec_chk("R8 mode11 rd", 20'hE0010, 0, 1, 1);
        dec_chk("R8 mode11 wr", 20'hEFFFF, 1, 1, 0);
        cfg_write(0, 8'h53, 8'h00);
        dec_chk("R8 mode00 rd", 20'hE4000, 0, 1, 0);
        dec_chk("R8 mode00 wr", 20'hE4000, 1, 1, 1);
        cfg_write(0, 8'h53, 8'h20);
        dec_chk("R8 mode01 rd", 20'hE8000, 0, 1, 0);
        dec_chk("R8 mode01 wr", 20'hE8000, 1, 1, 0);
        cfg_write(0, 8'h53, 8'h40);
        dec_chk("R8 mode10 rd", 20'hEC000, 0, 1, 1);
        dec_chk("R8 mode10 wr", 20'hEC000, 1, 1, 1);
        cfg_write(0, 8'h54, 8'h40);
        dec_chk("R7 seg2 on", 20'hEBFFF, 0, 1, 1);
        dec_chk("R7 seg1 off", 20'hE7FFF, 1, 0, 0);
        dec_chk("R7 seg3 off", 20'hEC000, 0, 0, 0);
        dec_chk("R9 above window", 20'hF8000, 0, 0, 0);
        dec_chk("R9 below window", 20'hD8000, 1, 0, 0);
    endtask

    task automatic t_soft_reset;
        cfg_write(0, 8'h54, 8'hF5);
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        cfg_func = 0; cfg_addr = 8'h50; cfg_wdata = 8'h11; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        cfg_read_chk("R10 r54 low nibble", 0, 8'h54, 8'h05);
        cfg_read_chk("R10 write dropped", 0, 8'h50, 8'hBC);
        dec_chk("R10 shadow off", 20'hE0000, 0, 0, 0);
        cfg_write(0, 8'h50, 8'h22);
        cfg_read_chk("R10 back to idle", 0, 8'h50, 8'h22);
    endtask

    initial begin
        #10000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_image;
        t_foreign_func;
        t_read_only;
        t_masks;
        t_shadow;
        t_soft_reset;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule